// File: doc/BRIEF.md
# Periodic Power-Cycle Sequencer

This block wraps an untrusted hardware unit and periodically forces it through a short power-off cycle. The goal is that no hidden internal state, such as a secret cycle counter, can outlive one validated operating interval. A down-counter measures the time the unit spends running. When the counter runs out, the sequencer runs a fixed handshake with the rest of the system. It first asks for the unit's instruction pointer to be saved and waits for the acknowledgement. It then asks for the pipeline to be flushed and waits again. After that it removes the unit's power enable and holds its reset for a small, fixed number of cycles. Finally it restores power, releases reset and restarts the counter.

Non-maskable interrupts come from sources that stay powered on. Every one of them goes through a small in-order queue. The queue is only presented to the unit while the unit is running, and it delivers one entry per cycle whenever the unit signals that it is ready. An interrupt that arrives while the queue is full, with no entry leaving in that cycle, is discarded and raises a sticky overflow flag.

The running period `PERIOD` must be chosen strictly shorter than the validation epoch of the guarded unit (for example, below 2^20 cycles when that is the epoch). `OFF_CYCLES` sets the off window and takes a value from 1 to 4. The save, flush and power switching happen outside this block and are only seen here as request and acknowledge signals.

Top module: `power_cycle_seq`

## Requirements
- R1: While rst_ni is low and right after it is released, unit_pwr_en_o=1, unit_rst_o=0, save_req_o=0, flush_req_o=0, irq_valid_o=0 and nmi_ovf_o=0, and the running period starts afresh.
- R2: The running phase lasts exactly PERIOD rising edges. This is counted from the release of rst_ni, or from the first cycle in which unit_rst_o is low after a restore. save_req_o is high in the cycle after those edges.
- R3: save_req_o stays high until save_ack_i is sampled high on a rising edge. In the next cycle save_req_o=0 and flush_req_o=1. While save_req_o is high, flush_req_o stays low and power stays on.
- R4: flush_req_o stays high until flush_ack_i is sampled high. In the next cycle unit_pwr_en_o=0. save_ack_i and flush_ack_i have no effect outside their own request phase; an acknowledge during the running phase does not change the period.
- R5: In the off window, unit_pwr_en_o=0 and unit_rst_o=1 for exactly OFF_CYCLES consecutive cycles.
- R6: The off window is followed by exactly one cycle with unit_pwr_en_o=1 and unit_rst_o=1. In the cycle after that, unit_rst_o=0 and the running phase begins.
- R7: irq_valid_o is never high while unit_rst_o=1 or unit_pwr_en_o=0. An interrupt (nmi_valid_i=1 at a rising edge) that arrives during the handshake, the off window or the restore cycle is queued and not dropped, as long as there is space.
- R8: Queued interrupts come out on irq_id_o in arrival order, one per cycle for each cycle in which irq_valid_o and irq_ready_i are both high. While irq_ready_i is low, irq_valid_o and irq_id_o hold.
- R9: During the running phase, an interrupt that arrives at an edge when the queue is empty makes irq_valid_o high, with its id, in the next cycle.
- R10: An interrupt that arrives while the queue holds FIFO_DEPTH entries, with no entry leaving in that cycle, is dropped. nmi_ovf_o then goes high and stays high until rst_ni is low. Filling the queue to exactly FIFO_DEPTH entries does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_req_o | output | 1 | Request to save the unit's instruction pointer |
| save_ack_i | input | 1 | Save completed |
| flush_req_o | output | 1 | Request to flush the unit's pipeline |
| flush_ack_i | input | 1 | Flush completed |
| unit_pwr_en_o | output | 1 | Power enable of the guarded unit |
| unit_rst_o | output | 1 | Reset held on the guarded unit, active high |
| nmi_valid_i | input | 1 | Non-maskable interrupt arrives this cycle |
| nmi_id_i | input | IRQ_W | Id of the arriving interrupt |
| irq_valid_o | output | 1 | Interrupt offered to the unit |
| irq_id_o | output | IRQ_W | Id of the offered interrupt |
| irq_ready_i | input | 1 | Unit accepts the offered interrupt |
| nmi_ovf_o | output | 1 | Sticky flag: an interrupt was dropped |

## Verification
A corrupted period counter shows up at the ports as save_req_o rising one or more cycles early or late. It becomes visible by the end of the first running phase. A wrong sequencer state shows up within a cycle or two: the requests overlap, power drops without a flush acknowledge, or the off window has the wrong length. Bad queue pointers show up at the first drain after a power cycle: ids come out of order, an id repeats, the valid signal is missing or extra, or the overflow flag is set at exactly full. Interrupts queued while the unit is off stay invisible until the restore, so the bench drives them through every phase of the handshake.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SAVE    = 3'd1,
    ST_FLUSH   = 3'd2,
    ST_OFF     = 3'd3,
    ST_RESTORE = 3'd4
  } psr_state_e;
endpackage

// File: rtl/psr_period_cnt.sv
module psr_period_cnt #(
  parameter int unsigned PERIOD = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic reload_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= RELOAD;
    else if (reload_i)                cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2
  no_count_outside_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> (expired_o == $past(expired_o)));
endmodule

// File: rtl/psr_seq_fsm.sv
module psr_seq_fsm
  import psr_pkg::*;
#(
  parameter int unsigned OFF_CYCLES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       expired_i,
  input  logic       save_ack_i,
  input  logic       flush_ack_i,
  output psr_state_e state_o,
  output logic       save_req_o,
  output logic       flush_req_o,
  output logic       pwr_en_o,
  output logic       unit_rst_o
);
  localparam int unsigned OFF_W = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1;
  localparam logic [OFF_W-1:0] OFF_LOAD = OFF_W'(OFF_CYCLES - 1);

  psr_state_e       state_q, state_d;
  logic [OFF_W-1:0] off_cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (expired_i)         state_d = ST_SAVE;
      ST_SAVE:    if (save_ack_i)        state_d = ST_FLUSH;
      ST_FLUSH:   if (flush_ack_i)       state_d = ST_OFF;
      ST_OFF:     if (off_cnt_q == '0)   state_d = ST_RESTORE;
      ST_RESTORE:                        state_d = ST_RUN;
      default:                           state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      off_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FLUSH && flush_ack_i) off_cnt_q <= OFF_LOAD;
      else if (state_q == ST_OFF && off_cnt_q != '0) off_cnt_q <= off_cnt_q - 1'b1;
    end
  end

  assign state_o     = state_q;
  assign save_req_o  = (state_q == ST_SAVE);
  assign flush_req_o = (state_q == ST_FLUSH);
  assign pwr_en_o    = (state_q != ST_OFF);
  assign unit_rst_o  = (state_q == ST_OFF) || (state_q == ST_RESTORE);

  // checker: length of the current off window
  logic [7:0] off_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               off_len_q <= '0;
    else if (state_q == ST_OFF) off_len_q <= off_len_q + 1'b1;
    else                       off_len_q <= '0;
  end

  // R3
  req_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(save_req_o && flush_req_o));
  // R3
  flush_after_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_req_o) |-> $past(save_req_o && save_ack_i));
  // R4
  off_after_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> $past(flush_req_o && flush_ack_i));
  // R5
  off_holds_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> unit_rst_o);
  // R5
  off_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESTORE) |-> (off_len_q == 8'(OFF_CYCLES)));
  // R6
  restore_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_o && unit_rst_o) |=> !unit_rst_o);
endmodule

// File: rtl/psr_nmi_fifo.sv
module psr_nmi_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] id_i,
  input  logic         allow_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] id_o,
  output logic         ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full, pop, accept, drop;

  assign full    = (cnt_q == FULL);
  assign valid_o = allow_i && (cnt_q != '0);
  assign pop     = valid_o && ready_i;
  assign accept  = push_i && (!full || pop);
  assign drop    = push_i && full && !pop;
  assign id_o    = mem_q[rd_q];
  assign ovf_o   = ovf_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '0;
      else if (accept && wr_q == PTR_W'(i))    mem_q[i] <= id_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (accept) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)    rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (accept && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !accept) cnt_q <= cnt_q - 1'b1;
      if (drop) ovf_q <= 1'b1;
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R8
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> $stable(id_o));
endmodule

// File: rtl/power_cycle_seq.sv
module power_cycle_seq
  import psr_pkg::*;
#(
  parameter int unsigned PERIOD     = 10_000_000,
  parameter int unsigned OFF_CYCLES = 2,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned IRQ_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             save_req_o,
  input  logic             save_ack_i,
  output logic             flush_req_o,
  input  logic             flush_ack_i,
  output logic             unit_pwr_en_o,
  output logic             unit_rst_o,
  input  logic             nmi_valid_i,
  input  logic [IRQ_W-1:0] nmi_id_i,
  output logic             irq_valid_o,
  output logic [IRQ_W-1:0] irq_id_o,
  input  logic             irq_ready_i,
  output logic             nmi_ovf_o
);
  psr_state_e state;
  logic       expired, in_run;

  assign in_run = (state == ST_RUN);

  psr_period_cnt #(.PERIOD(PERIOD)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (in_run),
    .reload_i  (state == ST_RESTORE),
    .expired_o (expired)
  );

  psr_seq_fsm #(.OFF_CYCLES(OFF_CYCLES)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .expired_i   (expired),
    .save_ack_i  (save_ack_i),
    .flush_ack_i (flush_ack_i),
    .state_o     (state),
    .save_req_o  (save_req_o),
    .flush_req_o (flush_req_o),
    .pwr_en_o    (unit_pwr_en_o),
    .unit_rst_o  (unit_rst_o)
  );

  psr_nmi_fifo #(.DEPTH(FIFO_DEPTH), .W(IRQ_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (nmi_valid_i),
    .id_i    (nmi_id_i),
    .allow_i (in_run),
    .ready_i (irq_ready_i),
    .valid_o (irq_valid_o),
    .id_o    (irq_id_o),
    .ovf_o   (nmi_ovf_o)
  );

  // checker: cycles spent in the running phase
  int unsigned run_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len_q <= 0;
    else if (in_run) run_len_q <= run_len_q + 1;
    else             run_len_q <= 0;
  end

  // R2
  period_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(save_req_o) |-> (run_len_q == PERIOD));
  // R7
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (unit_pwr_en_o && !unit_rst_o));
  // R4
  ack_ignored_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unit_rst_o && !save_req_o && !flush_req_o && !expired) |=> !save_req_o);
endmodule

// File: tb/power_cycle_seq_bench.sv
module power_cycle_seq_bench;
  localparam int P   = 16;
  localparam int OFF = 3;
  localparam int D   = 4;
  localparam int W   = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic save_ack = 1'b0, flush_ack = 1'b0;
  logic nmi_v = 1'b0;
  logic [W-1:0] nmi_id = '0;
  logic irq_ready = 1'b1;
  logic save_req, flush_req, pwr_en, urst, irq_v, ovf;
  logic [W-1:0] irq_id;

  int errors = 0, checks = 0;
  bit done = 0;

  int exp_q [64];
  int hd = 0, tl = 0;
  int next_id = 1;
  int sent = 0, k_cur = 0;
  bit ovf_exp = 0;

  always #5 clk = ~clk;

  power_cycle_seq #(.PERIOD(P), .OFF_CYCLES(OFF), .FIFO_DEPTH(D), .IRQ_W(W)) u_power_cycle_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .save_req_o(save_req), .save_ack_i(save_ack),
    .flush_req_o(flush_req), .flush_ack_i(flush_ack),
    .unit_pwr_en_o(pwr_en), .unit_rst_o(urst),
    .nmi_valid_i(nmi_v), .nmi_id_i(nmi_id),
    .irq_valid_o(irq_v), .irq_id_o(irq_id), .irq_ready_i(irq_ready),
    .nmi_ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // drive one interrupt per sample outside the running phase until k_cur are sent
  task automatic inject();
    if (sent < k_cur) begin
      nmi_v  = 1'b1;
      nmi_id = W'(next_id);
      if (tl - hd < D) begin exp_q[tl % 64] = next_id; tl++; end
      else ovf_exp = 1;
      next_id++;
      sent++;
    end else nmi_v = 1'b0;
  endtask

  task automatic check_reset_state();
    chk(pwr_en == 1'b1 && urst == 1'b0, "R1", "power on, reset low", {pwr_en, urst}, 2);
    chk(save_req == 1'b0 && flush_req == 1'b0, "R1", "no requests", {save_req, flush_req}, 0);
    chk(irq_v == 1'b0, "R1", "irq_valid low", irq_v, 0);
    chk(ovf == 1'b0, "R1", "overflow clear", ovf, 0);
  endtask

  // running phase from current sample (first RUN sample) until save_req is seen
  task automatic run_phase(input bit stall, input string tag);
    int n = 0;
    while (!save_req && n < 10 * P) begin
      irq_ready = !(stall && n < 2);
      if (n == 3) begin save_ack = 1'b1; flush_ack = 1'b1; end
      else begin save_ack = 1'b0; flush_ack = 1'b0; end
      if (hd != tl) begin
        chk(irq_v == 1'b1, "R8", "queued irq offered", irq_v, 1);
        chk(irq_id == W'(exp_q[hd % 64]), "R8", "irq order", irq_id, exp_q[hd % 64]);
        if (irq_ready) hd++;
      end else begin
        chk(irq_v == 1'b0, "R9", "no spurious irq", irq_v, 0);
      end
      if (n == 8) begin
        nmi_v = 1'b1; nmi_id = W'(8'hA5);
        exp_q[tl % 64] = 8'hA5; tl++;
      end else nmi_v = 1'b0;
      step();
      n++;
    end
    save_ack = 1'b0; flush_ack = 1'b0; nmi_v = 1'b0; irq_ready = 1'b1;
    chk(n == P, "R2", {tag, " period length"}, n, P);
    chk(hd == tl, "R8", "queue drained in run", tl - hd, 0);
  endtask

  task automatic episode(input int ds, input int df, input int k, input bit stall);
    int c, offs;
    k_cur = k; sent = 0;
    // save phase
    for (c = 0; c < ds; c++) begin
      chk(save_req && !flush_req && pwr_en, "R3", "save held before ack", {save_req, flush_req, pwr_en}, 5);
      chk(!irq_v, "R7", "irq gated in save", irq_v, 0);
      inject(); step();
    end
    chk(save_req == 1'b1, "R3", "save still requested", save_req, 1);
    save_ack = 1'b1; inject(); step(); save_ack = 1'b0;
    chk(!save_req && flush_req, "R3", "save->flush", {save_req, flush_req}, 1);
    // flush phase
    for (c = 0; c < df; c++) begin
      chk(flush_req && pwr_en, "R4", "flush held before ack", {flush_req, pwr_en}, 3);
      chk(!irq_v, "R7", "irq gated in flush", irq_v, 0);
      inject(); step();
    end
    flush_ack = 1'b1; inject(); step(); flush_ack = 1'b0;
    chk(pwr_en == 1'b0, "R4", "power dropped after flush ack", pwr_en, 0);
    // off window
    offs = 0;
    while (!pwr_en && offs < 10) begin
      chk(urst == 1'b1, "R5", "reset held while off", urst, 1);
      chk(!irq_v, "R7", "irq gated while off", irq_v, 0);
      inject(); step(); offs++;
    end
    chk(offs == OFF, "R5", "off window length", offs, OFF);
    // restore cycle
    chk(pwr_en && urst, "R6", "restore cycle", {pwr_en, urst}, 3);
    chk(!irq_v, "R7", "irq gated in restore", irq_v, 0);
    inject(); step();
    chk(urst == 1'b0 && pwr_en, "R6", "running after restore", {pwr_en, urst}, 2);
    chk(sent == k, "R7", "all injected", sent, k);
    chk(ovf == ovf_exp, "R10", "overflow flag", ovf, ovf_exp);
    run_phase(stall, "R2");
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_ni = 1'b1;
    check_reset_state();
    run_phase(0, "R1");
    for (int i = 0; i < 9; i++) begin
      episode(i / 3, i % 3, i % 6, i[0]);
    end
    chk(ovf == 1'b1, "R10", "overflow sticky", ovf, 1);
    // reset in the middle of a handshake
    save_ack = 1'b0;
    step(); step();
    rst_ni = 1'b0;
    step();
    check_reset_state();
    rst_ni = 1'b1;
    run_phase(0, "R1");
    chk(ovf == 1'b0, "R1", "overflow cleared by reset", ovf, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule